// File: doc/BRIEF.md
# Buffer-Side Transfer FIFO with Hysteresis Request

This block is a synchronous first-in first-out store, one 32-bit word wide, that sits between a shared memory buffer and a streaming port. Its depth is fixed at elaboration and must be a multiple of 8 from 8 to 128 words. The almost-full threshold is an input that can change at run time. A chip normally carries two copies with separately chosen depths: one faces the host and one faces the disc.

Besides the usual flags, the block drives a transfer request toward the buffer arbiter. That request is a two-state hysteresis machine. In fill mode (`drain_mode` = 0) the FIFO feeds a consumer: the request is raised once the FIFO has gone empty and is held until almost full is reached. In drain mode (`drain_mode` = 1) the FIFO is fed by a producer: the request is raised at almost full and held until the FIFO has been emptied.

The machine has two states. REQ_IDLE drives the request low and REQ_ACTIVE drives it high. The START transition (REQ_IDLE to REQ_ACTIVE) fires on empty in fill mode and on almost full in drain mode. The STOP transition (REQ_ACTIVE to REQ_IDLE) fires on almost full in fill mode and on empty in drain mode. In every other case the state holds. The read port is show-ahead: `rd_data` presents the oldest word whenever `empty` is low, and a read pops that word.

Top module: `xfer_fifo`

## Requirements
- R1: While `rst_n` is low, `empty`=1, `full`=0, `almost_full`=0, `level`=0, `overflow`=0, `underflow`=0 and `xfer_req`=0.
- R2: Words leave through `rd_data` in the order in which they were accepted, with all 32 bits unchanged.
- R3: `level` counts the words held, from 0 to DEPTH. `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is DEPTH. A read and a write accepted in the same cycle leave `level` unchanged.
- R4: `almost_full` is 1 whenever `level` is at least the effective threshold.
- R5: The effective threshold is `af_level` clamped to the range 1..DEPTH. A value of 0 acts as 1, and a value above DEPTH acts as DEPTH.
- R6: A write while `full` is dropped, and the stored contents and `level` stay as they were. The write sets `overflow`, which then stays at 1 until reset.
- R7: A read while `empty` is ignored, and `level` stays at 0. The read sets `underflow`, which then stays at 1 until reset.
- R8: In fill mode, `xfer_req` rises on the clock edge after a cycle in which `empty` is 1. It falls on the edge after a cycle in which `almost_full` is 1. Otherwise it holds.
- R9: In drain mode, `xfer_req` rises on the edge after a cycle in which `almost_full` is 1. It falls on the edge after a cycle in which `empty` is 1. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| drain_mode | input | 1 | 0 selects fill polarity for the request, 1 selects drain polarity |
| af_level | input | CNT_W | Almost-full threshold in words, clamped to 1..DEPTH |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to write |
| full | output | 1 | FIFO holds DEPTH words |
| rd_en | input | 1 | Read strobe; pops the word shown on `rd_data` |
| rd_data | output | WIDTH | Oldest stored word (show-ahead) |
| empty | output | 1 | FIFO holds no words |
| level | output | CNT_W | Number of words held |
| almost_full | output | 1 | `level` is at or above the effective threshold |
| overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |
| underflow | output | 1 | Sticky: a read was ignored because the FIFO was empty |
| xfer_req | output | 1 | Registered transfer request toward the buffer arbiter |

## Verification
The request properties assume that `drain_mode` changes only while reset is held. A polarity change in mid-run would leave the machine in a state that belonged to the other mode. The bench therefore sets the mode and a starting threshold inside each reset pulse. After that it changes only `af_level` at run time, which the properties allow because `almost_full` follows the threshold combinationally and the machine samples that same signal. Strobes are driven on the falling edge, so every property sees stable inputs at the rising edge.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

    // Request hysteresis states
    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_e;

    // Request polarity
    typedef enum logic {
        MODE_FILL  = 1'b0,
        MODE_DRAIN = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/xf_store.sv
module xf_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_nxt;
    logic [PTR_W-1:0] rd_nxt;

    // A power-of-two depth wraps by itself; other legal depths compare against the last slot
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + PTR_W'(1);
            assign rd_nxt = rd_ptr + PTR_W'(1);
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/xf_level.sv
module xf_level #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] threshold,
    output logic             push,
    output logic             pop,
    output logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic             almost_full,
    output logic             overflow,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] th_eff;

    assign empty = (count == '0);
    assign full  = (count == CAP);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;
    assign level = count;

    // Clamp the run-time threshold into 1..DEPTH
    always_comb begin
        if (threshold == '0)
            th_eff = ONE;
        else if (threshold > CAP)
            th_eff = CAP;
        else
            th_eff = threshold;
    end

    assign almost_full = (count >= th_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   count <= count + ONE;
                2'b01:   count <= count - ONE;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (wr_en && full)  overflow  <= 1'b1;
            if (rd_en && empty) underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/xf_req_fsm.sv
module xf_req_fsm
    import xfer_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drain_mode,
    input  logic empty,
    input  logic almost_full,
    output logic req
);
    req_state_e state;
    req_state_e state_nxt;
    xfer_mode_e mode;
    logic       start_cond;
    logic       stop_cond;

    assign mode = xfer_mode_e'(drain_mode);

    always_comb begin
        unique case (mode)
            MODE_FILL: begin
                start_cond = empty;
                stop_cond  = almost_full;
            end
            MODE_DRAIN: begin
                start_cond = almost_full;
                stop_cond  = empty;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REQ_IDLE;
        else        state <= state_nxt;
    end

    // START / STOP transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            REQ_IDLE:   if (start_cond) state_nxt = REQ_ACTIVE;
            REQ_ACTIVE: if (stop_cond)  state_nxt = REQ_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state)
            REQ_IDLE:   req = 1'b0;
            REQ_ACTIVE: req = 1'b1;
        endcase
    end

endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drain_mode,
    input  logic [CNT_W-1:0] af_level,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic [CNT_W-1:0] level,
    output logic             almost_full,
    output logic             overflow,
    output logic             underflow,
    output logic             xfer_req
);
    logic push;
    logic pop;

    xf_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .threshold   (af_level),
        .push        (push),
        .pop         (pop),
        .level       (level),
        .empty       (empty),
        .full        (full),
        .almost_full (almost_full),
        .overflow    (overflow),
        .underflow   (underflow)
    );

    xf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (wr_data),
        .dout  (rd_data)
    );

    xf_req_fsm u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .drain_mode  (drain_mode),
        .empty       (empty),
        .almost_full (almost_full),
        .req         (xfer_req)
    );

endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             drain_mode,
    input logic [CNT_W-1:0] af_level,
    input logic             wr_en,
    input logic             rd_en,
    input logic             full,
    input logic             empty,
    input logic [CNT_W-1:0] level,
    input logic             almost_full,
    input logic             overflow,
    input logic             underflow,
    input logic             xfer_req
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CAP);

    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (full && overflow));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (empty && underflow));

    p_udf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    p_full_af_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);

    p_zero_th_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (af_level == '0 && !empty) |-> almost_full);

    p_fill_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_mode && empty) |=> xfer_req);

    p_fill_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_mode && almost_full) |=> !xfer_req);

    p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_mode && !empty && !almost_full) |=> $stable(xfer_req));

    p_drain_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && almost_full) |=> xfer_req);

    p_drain_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && empty) |=> !xfer_req);

    p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && !empty && !almost_full) |=> $stable(xfer_req));

endmodule

bind xfer_fifo xfer_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drain_mode  (drain_mode),
    .af_level    (af_level),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .full        (full),
    .empty       (empty),
    .level       (level),
    .almost_full (almost_full),
    .overflow    (overflow),
    .underflow   (underflow),
    .xfer_req    (xfer_req)
);

// File: tb/xfer_fifo_bench.sv
module xfer_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH = 32;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             drain_mode = 1'b0;
    logic [CNT_W-1:0] af_level = '0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             full;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             empty;
    logic [CNT_W-1:0] level;
    logic             almost_full;
    logic             overflow;
    logic             underflow;
    logic             xfer_req;

    xfer_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_xfer_fifo (
        .clk(clk), .rst_n(rst_n), .drain_mode(drain_mode), .af_level(af_level),
        .wr_en(wr_en), .wr_data(wr_data), .full(full), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .level(level),
        .almost_full(almost_full), .overflow(overflow), .underflow(underflow),
        .xfer_req(xfer_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [WIDTH-1:0] exp_q [$];
    int mlevel = 0;
    int n_run = 0;
    int n_fail = 0;
    int seed_word = 32'h5A00_0000;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: a popped word must match the oldest queued word (R2)
    always @(negedge clk) begin
        #2;
        if (rst_n && rd_en && !empty) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 actual=%h expected=<no word queued>", rd_data);
            end else begin
                logic [WIDTH-1:0] want;
                want = exp_q.pop_front();
                if (rd_data !== want) begin
                    n_fail++;
                    $display("FAIL R2 actual=%h expected=%h", rd_data, want);
                end
            end
        end
    end

    // Driver: one cycle of strobes, with the bench's own expectation of acceptance
    task automatic drive(input logic we, input logic re);
        bit wok;
        bit rok;
        @(negedge clk);
        seed_word = seed_word + 32'h0001_0003;
        wr_en   = we;
        wr_data = seed_word;
        rd_en   = re;
        wok = we && (mlevel < DEPTH);
        rok = re && (mlevel > 0);
        if (wok) exp_q.push_back(seed_word);
        mlevel = mlevel + int'(wok) - int'(rok);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0);
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1);
    endtask

    task automatic do_reset(input logic mode, input int th);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        drain_mode = mode;
        af_level = CNT_W'(th);
        exp_q.delete();
        mlevel = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 almost_full", int'(almost_full), 0);
        chk("R1 level", int'(level), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 underflow", int'(underflow), 0);
        chk("R1 xfer_req", int'(xfer_req), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // ---------------- fill mode, threshold 12 ----------------
        do_reset(1'b0, 12);
        idle();
        chk("R8 request after empty", int'(xfer_req), 1);
        write_n(11);
        idle();
        chk("R3 level 11", int'(level), 11);
        chk("R4 below threshold", int'(almost_full), 0);
        chk("R8 hold while filling", int'(xfer_req), 1);
        write_n(1);
        idle();
        chk("R4 at threshold", int'(almost_full), 1);
        chk("R8 one-cycle latency on stop", int'(xfer_req), 1);
        idle();
        chk("R8 stop at almost full", int'(xfer_req), 0);
        read_n(12);
        idle();
        chk("R3 empty after drain", int'(empty), 1);
        chk("R8 one-cycle latency on start", int'(xfer_req), 0);
        idle();
        chk("R8 restart on empty", int'(xfer_req), 1);

        // overflow and underflow
        write_n(16);
        idle();
        chk("R3 full", int'(full), 1);
        chk("R3 level DEPTH", int'(level), DEPTH);
        write_n(2);
        idle();
        chk("R6 overflow sticky set", int'(overflow), 1);
        chk("R6 level kept", int'(level), DEPTH);
        read_n(16);
        idle();
        chk("R3 empty", int'(empty), 1);
        chk("R6 overflow remains", int'(overflow), 1);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        read_n(2);
        idle();
        chk("R7 underflow set", int'(underflow), 1);
        chk("R7 level stays 0", int'(level), 0);
        idle();
        chk("R7 underflow sticky", int'(underflow), 1);

        // ---------------- threshold clamping ----------------
        do_reset(1'b0, 0);
        idle();
        write_n(1);
        idle();
        chk("R5 zero threshold acts as 1", int'(almost_full), 1);
        af_level = CNT_W'(31);
        #1;
        chk("R5 large threshold low at 1", int'(almost_full), 0);
        write_n(14);
        idle();
        chk("R5 large threshold low at 15", int'(almost_full), 0);
        write_n(1);
        idle();
        chk("R5 large threshold acts as DEPTH", int'(almost_full), 1);
        read_n(16);
        idle();

        // ---------------- drain mode, threshold 8 ----------------
        do_reset(1'b1, 8);
        idle();
        chk("R9 no request when empty", int'(xfer_req), 0);
        idle();
        chk("R9 still idle", int'(xfer_req), 0);
        write_n(7);
        idle();
        chk("R9 below threshold", int'(xfer_req), 0);
        write_n(1);
        idle();
        chk("R4 drain threshold", int'(almost_full), 1);
        chk("R9 one-cycle latency on start", int'(xfer_req), 0);
        idle();
        chk("R9 start at almost full", int'(xfer_req), 1);
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1);
        idle();
        chk("R3 simultaneous read and write", int'(level), 8);
        read_n(4);
        idle();
        chk("R3 level 4", int'(level), 4);
        chk("R9 hold while emptying", int'(xfer_req), 1);
        read_n(4);
        idle();
        chk("R9 one-cycle latency on stop", int'(xfer_req), 1);
        idle();
        chk("R9 stop at empty", int'(xfer_req), 0);
        chk("R2 all words returned", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule